// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the entry sequence of a 32-bit RISC core when it takes a general exception, a TLB-miss exception, a trap, an accepted interrupt or a manual reset. It also performs the power-on reset of the core's control state. It owns the program counter pair, the status register, the vector base, the floating-point status register and the shadow registers. It also owns the cause registers and the two banks of the low eight general registers. On each entry it saves the interrupted context, records the cause, redirects the program counter and raises the privilege, block and bank bits, all on one clock edge.

Outside an entry, the core's decode logic loads the program counter, writes the status, vector-base and FP-status registers, and reads and writes the visible bank. The delay-slot flag follows a per-cycle input from decode. The controller uses this flag to pick the slot variant of a general exception code. Two status bits choose which bank of R0..R7 is visible: the privilege bit (bit 30) and the bank bit (bit 29). Whenever their AND changes, the visible bank and the shadow bank exchange roles.

Top module: `excEntryCtl`

## Requirements
- R1: While rstN is low at a clock edge, the next state is: pc = 0xA0000000, nextPc = 0xA0000002, sr = 0x700000F0, fpscr = 0x00040001, vbr = 0, expevt = 0, intevt = 0, tra = 0, delaySlot = 0, and all banked registers zero.
- R2: A manual reset request loads pc = 0xA0000000 and nextPc = 0xA0000002, and writes resetCode into expevt. It ORs sr with bits 30, 29 and 28 and with the mask field bits 7:4 = 4'hF. It leaves spc, ssr and sgr unchanged.
- R3: A general, TLB-miss, trap or interrupt entry copies pc into spc, sr into ssr and r15In into sgr.
- R4: A general, TLB-miss, trap or interrupt entry ORs bits 30 (privilege), 29 (bank) and 28 (block) into sr and keeps every other sr bit.
- R5: A general exception or trap jumps to vbr+0x100, a TLB miss to vbr+0x400 and an interrupt to vbr+0x600. After any entry, nextPc is the new pc plus 2.
- R6: A general exception writes genCode into expevt, or genSlotCode when delaySlot is 1. A TLB miss writes tlbCode. A trap writes the fixed code 0x160. An interrupt writes irqCode into intevt and leaves expevt unchanged.
- R7: A trap writes tra = trapImm shifted left by 2, zero-extended to 32 bits.
- R8: In a cycle with no entry, delaySlot takes slotIn. Any entry, including a manual reset, clears delaySlot.
- R9: When requests coincide, the order is reset, then general, then TLB miss, then trap, then interrupt. A losing request changes none of expevt, intevt, tra, spc or the vector chosen.
- R10: The readable bank R0..R7 (gprRdData) exchanges with the shadow bank (shadowRdData) exactly when sr[30] AND sr[29] changes value, whether sr was changed by a software write or by an entry.
- R11: In a cycle with no entry, pcLoad sets pc = pcLoadVal and nextPc = pcLoadVal + 2. An entry in the same cycle overrides pcLoad and srWrEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low power-on reset |
| reqReset | input | 1 | Manual reset request |
| resetCode | input | 12 | Cause code for the manual reset |
| reqGen | input | 1 | General exception request |
| genCode | input | 12 | Normal general exception code |
| genSlotCode | input | 12 | Code used when the fault is in a delay slot |
| reqTlb | input | 1 | TLB-miss exception request |
| tlbCode | input | 12 | TLB-miss cause code |
| reqTrap | input | 1 | Trap request |
| trapImm | input | 8 | Trap immediate |
| reqIrq | input | 1 | Accepted interrupt |
| irqCode | input | 12 | Interrupt event code |
| slotIn | input | 1 | Next-cycle delay-slot state from decode |
| pcLoad | input | 1 | Normal program counter load |
| pcLoadVal | input | 32 | Value for pcLoad |
| srWrEn | input | 1 | Status register write |
| srWrData | input | 32 | Status write value |
| vbrWrEn | input | 1 | Vector base write |
| vbrWrData | input | 32 | Vector base value |
| fpscrWrEn | input | 1 | FP status write |
| fpscrWrData | input | 32 | FP status value |
| gprWrEn | input | 1 | Write to visible bank register |
| gprWrIdx | input | 3 | Visible bank register index |
| gprWrData | input | 32 | Write data |
| gprRdIdx | input | 3 | Read index for both bank outputs |
| r15In | input | 32 | Current R15, saved on entry |
| pc | output | 32 | Program counter |
| nextPc | output | 32 | Following program counter |
| sr | output | 32 | Status register |
| ssr | output | 32 | Saved status |
| spc | output | 32 | Saved program counter |
| sgr | output | 32 | Saved R15 |
| vbr | output | 32 | Vector base |
| fpscr | output | 32 | FP status register |
| expevt | output | 12 | Exception and reset cause |
| intevt | output | 12 | Interrupt cause |
| tra | output | 32 | Trap immediate register |
| delaySlot | output | 1 | Delay-slot flag |
| gprRdData | output | 32 | Visible bank register at gprRdIdx |
| shadowRdData | output | 32 | Shadow bank register at gprRdIdx |

## Verification
Every register result of an entry, a reset or a software write appears one clock edge after the request is sampled, because all state updates share that single edge. The bank read ports are combinational over that state. The bench drives inputs just after a falling edge and samples at the next falling edge, half a period after the updating rising edge. Each entry is preceded by a set-up cycle, so the pc, sr and delay-slot values it saves are known.

// File: rtl/excEntryPkg.sv
package excEntryPkg;

  // status register bit positions the entry logic depends on
  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;
  localparam int SR_IMASK_LO = 4;
  localparam int SR_IMASK_W = 4;

  typedef enum logic [1:0] {
    VS_RESET = 2'd0,
    VS_GEN   = 2'd1,
    VS_TLB   = 2'd2,
    VS_IRQ   = 2'd3
  } vecSelT;

  typedef enum logic [2:0] {
    XS_RESET = 3'd0,
    XS_GEN   = 3'd1,
    XS_SLOT  = 3'd2,
    XS_TLB   = 3'd3,
    XS_TRAP  = 3'd4
  } expSelT;

  typedef struct packed {
    logic   take;
    logic   isReset;
    logic   saveCtx;
    logic   wrExp;
    logic   wrInt;
    logic   wrTra;
    vecSelT vecSel;
    expSelT expSel;
  } entryStbT;

endpackage

// File: rtl/excEntryCtrl.sv
module excEntryCtrl
  import excEntryPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqReset,
  input  logic     reqGen,
  input  logic     reqTlb,
  input  logic     reqTrap,
  input  logic     reqIrq,
  input  logic     delaySlot,
  output entryStbT stb
);

  always_comb begin
    stb = '0;
    stb.vecSel = VS_RESET;
    stb.expSel = XS_RESET;
    if (reqReset) begin
      stb.take    = 1'b1;
      stb.isReset = 1'b1;
      stb.wrExp   = 1'b1;
    end else if (reqGen) begin
      stb.take    = 1'b1;
      stb.saveCtx = 1'b1;
      stb.wrExp   = 1'b1;
      stb.vecSel  = VS_GEN;
      stb.expSel  = delaySlot ? XS_SLOT : XS_GEN;
    end else if (reqTlb) begin
      stb.take    = 1'b1;
      stb.saveCtx = 1'b1;
      stb.wrExp   = 1'b1;
      stb.vecSel  = VS_TLB;
      stb.expSel  = XS_TLB;
    end else if (reqTrap) begin
      stb.take    = 1'b1;
      stb.saveCtx = 1'b1;
      stb.wrExp   = 1'b1;
      stb.wrTra   = 1'b1;
      stb.vecSel  = VS_GEN;
      stb.expSel  = XS_TRAP;
    end else if (reqIrq) begin
      stb.take    = 1'b1;
      stb.saveCtx = 1'b1;
      stb.wrInt   = 1'b1;
      stb.vecSel  = VS_IRQ;
    end
  end

  // R9: a reset request always wins the arbitration
  a_r9_reset_first: assert property (@(posedge clk) disable iff (!rstN)
    reqReset |-> (stb.isReset && !stb.saveCtx && !stb.wrInt));

  // R9: an interrupt never writes its cause when anything else is requested
  a_r9_irq_last: assert property (@(posedge clk) disable iff (!rstN)
    (reqIrq && (reqReset || reqGen || reqTlb || reqTrap)) |-> !stb.wrInt);

endmodule

// File: rtl/excBankFile.sv
module excBankFile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bankSel,
  input  logic            wrEn,
  input  logic [IW-1:0]   wrIdx,
  input  logic [XLEN-1:0] wrData,
  input  logic [IW-1:0]   rdIdx,
  output logic [XLEN-1:0] rdVis,
  output logic [XLEN-1:0] rdShd
);

  // physical bank A is visible while bankSel = 0, bank B while bankSel = 1;
  // flipping bankSel is the exchange of the two banks
  logic [XLEN-1:0] bankA [NREG];
  logic [XLEN-1:0] bankB [NREG];
  logic [NREG-1:0] hitA;
  logic [NREG-1:0] hitB;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hitA[g] = wrEn && !bankSel && (wrIdx == IW'(g));
    assign hitB[g] = wrEn &&  bankSel && (wrIdx == IW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rstN) begin
        bankA[i] <= '0;
        bankB[i] <= '0;
      end else begin
        if (hitA[i]) bankA[i] <= wrData;
        if (hitB[i]) bankB[i] <= wrData;
      end
    end
  end

  assign rdVis = bankSel ? bankB[rdIdx] : bankA[rdIdx];
  assign rdShd = bankSel ? bankA[rdIdx] : bankB[rdIdx];

  logic [XLEN-1:0] vis0;
  logic [XLEN-1:0] shd0;
  assign vis0 = bankSel ? bankB[0] : bankA[0];
  assign shd0 = bankSel ? bankA[0] : bankB[0];

  // R10: when the selector flips without a write, the old visible R0 is now shadow
  a_r10_swap_moves: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((bankSel == $past(bankSel)) || (shd0 == $past(vis0))));

  // R10: with the selector steady and no write, the visible R0 keeps its value
  a_r10_no_swap: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((bankSel != $past(bankSel)) || (vis0 == $past(vis0))));

endmodule

// File: rtl/excEntryDatapath.sv
module excEntryDatapath
  import excEntryPkg::*;
#(
  parameter int XLEN = 32,
  parameter int CODE_W = 12,
  parameter int IMM_W = 8,
  parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0] SR_INIT = 32'h7000_00F0,
  parameter logic [XLEN-1:0] FPSCR_INIT = 32'h0004_0001,
  parameter int GEN_OFS = 'h100,
  parameter int TLB_OFS = 'h400,
  parameter int IRQ_OFS = 'h600,
  parameter logic [CODE_W-1:0] TRAP_CODE = 12'h160,
  parameter logic [CODE_W-1:0] POWER_CODE = 12'h000
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryStbT          stb,
  input  logic [CODE_W-1:0] resetCode,
  input  logic [CODE_W-1:0] genCode,
  input  logic [CODE_W-1:0] genSlotCode,
  input  logic [CODE_W-1:0] tlbCode,
  input  logic [IMM_W-1:0]  trapImm,
  input  logic [CODE_W-1:0] irqCode,
  input  logic              slotIn,
  input  logic              pcLoad,
  input  logic [XLEN-1:0]   pcLoadVal,
  input  logic              srWrEn,
  input  logic [XLEN-1:0]   srWrData,
  input  logic              vbrWrEn,
  input  logic [XLEN-1:0]   vbrWrData,
  input  logic              fpscrWrEn,
  input  logic [XLEN-1:0]   fpscrWrData,
  input  logic [XLEN-1:0]   r15In,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   nextPc,
  output logic [XLEN-1:0]   sr,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [XLEN-1:0]   vbr,
  output logic [XLEN-1:0]   fpscr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt,
  output logic [XLEN-1:0]   tra,
  output logic              delaySlot
);

  localparam logic [XLEN-1:0] MODE_BITS = (XLEN'(1) << SR_MD_BIT) |
                                          (XLEN'(1) << SR_RB_BIT) |
                                          (XLEN'(1) << SR_BL_BIT);
  localparam logic [XLEN-1:0] IMASK_BITS = XLEN'({SR_IMASK_W{1'b1}}) << SR_IMASK_LO;
  localparam logic [XLEN-1:0] INSN_STEP = XLEN'(2);

  logic [XLEN-1:0]   vecOfs;
  logic [XLEN-1:0]   tgtPc;
  logic [CODE_W-1:0] expVal;
  logic [XLEN-1:0]   srEntry;

  always_comb begin
    unique case (stb.vecSel)
      VS_GEN:  vecOfs = XLEN'(GEN_OFS);
      VS_TLB:  vecOfs = XLEN'(TLB_OFS);
      VS_IRQ:  vecOfs = XLEN'(IRQ_OFS);
      default: vecOfs = '0;
    endcase
    tgtPc = stb.isReset ? RESET_PC : (vbr + vecOfs);
    unique case (stb.expSel)
      XS_GEN:  expVal = genCode;
      XS_SLOT: expVal = genSlotCode;
      XS_TLB:  expVal = tlbCode;
      XS_TRAP: expVal = TRAP_CODE;
      default: expVal = resetCode;
    endcase
    srEntry = sr | MODE_BITS | (stb.isReset ? IMASK_BITS : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc        <= RESET_PC;
      nextPc    <= RESET_PC + INSN_STEP;
      sr        <= SR_INIT;
      ssr       <= '0;
      spc       <= '0;
      sgr       <= '0;
      vbr       <= '0;
      fpscr     <= FPSCR_INIT;
      expevt    <= POWER_CODE;
      intevt    <= '0;
      tra       <= '0;
      delaySlot <= 1'b0;
    end else begin
      if (stb.take) begin
        pc        <= tgtPc;
        nextPc    <= tgtPc + INSN_STEP;
        sr        <= srEntry;
        delaySlot <= 1'b0;
        if (stb.saveCtx) begin
          spc <= pc;
          ssr <= sr;
          sgr <= r15In;
        end
        if (stb.wrExp) expevt <= expVal;
        if (stb.wrInt) intevt <= irqCode;
        if (stb.wrTra) tra <= XLEN'({trapImm, 2'b00});
      end else begin
        delaySlot <= slotIn;
        if (pcLoad) begin
          pc     <= pcLoadVal;
          nextPc <= pcLoadVal + INSN_STEP;
        end
        if (srWrEn) sr <= srWrData;
      end
      if (vbrWrEn)   vbr   <= vbrWrData;
      if (fpscrWrEn) fpscr <= fpscrWrData;
    end
  end

  // R3: context captured from the cycle of the request
  a_r3_ctx_saved: assert property (@(posedge clk) disable iff (!rstN)
    stb.saveCtx |=> (spc == $past(pc)) && (ssr == $past(sr)) && (sgr == $past(r15In)));

  // R4: privilege, bank and block bits are all set after every entry
  a_r4_mode_bits: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> (sr[SR_MD_BIT] && sr[SR_RB_BIT] && sr[SR_BL_BIT]));

  // R5: the following pc is two bytes on from the entry target
  a_r5_next_pc: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> (nextPc == pc + INSN_STEP));

  // R8: no entry leaves the delay-slot flag set
  a_r8_slot_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> !delaySlot);

  // R2: a manual reset lands on the fixed address with the mask field full
  a_r2_reset_pc: assert property (@(posedge clk) disable iff (!rstN)
    stb.isReset |=> (pc == RESET_PC) && (sr[SR_IMASK_LO +: SR_IMASK_W] == '1));

  // R2: a manual reset leaves the saved context alone
  a_r2_no_save: assert property (@(posedge clk) disable iff (!rstN)
    stb.isReset |=> $stable(spc) && $stable(ssr) && $stable(sgr));

endmodule

// File: rtl/excEntryCtl.sv
module excEntryCtl
  import excEntryPkg::*;
#(
  parameter int XLEN = 32,
  parameter int CODE_W = 12,
  parameter int IMM_W = 8,
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqReset,
  input  logic [CODE_W-1:0] resetCode,
  input  logic              reqGen,
  input  logic [CODE_W-1:0] genCode,
  input  logic [CODE_W-1:0] genSlotCode,
  input  logic              reqTlb,
  input  logic [CODE_W-1:0] tlbCode,
  input  logic              reqTrap,
  input  logic [IMM_W-1:0]  trapImm,
  input  logic              reqIrq,
  input  logic [CODE_W-1:0] irqCode,
  input  logic              slotIn,
  input  logic              pcLoad,
  input  logic [XLEN-1:0]   pcLoadVal,
  input  logic              srWrEn,
  input  logic [XLEN-1:0]   srWrData,
  input  logic              vbrWrEn,
  input  logic [XLEN-1:0]   vbrWrData,
  input  logic              fpscrWrEn,
  input  logic [XLEN-1:0]   fpscrWrData,
  input  logic              gprWrEn,
  input  logic [IW-1:0]     gprWrIdx,
  input  logic [XLEN-1:0]   gprWrData,
  input  logic [IW-1:0]     gprRdIdx,
  input  logic [XLEN-1:0]   r15In,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   nextPc,
  output logic [XLEN-1:0]   sr,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [XLEN-1:0]   vbr,
  output logic [XLEN-1:0]   fpscr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt,
  output logic [XLEN-1:0]   tra,
  output logic              delaySlot,
  output logic [XLEN-1:0]   gprRdData,
  output logic [XLEN-1:0]   shadowRdData
);

  entryStbT stb;
  logic     bankSel;

  assign bankSel = sr[SR_MD_BIT] & sr[SR_RB_BIT];

  excEntryCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqReset  (reqReset),
    .reqGen    (reqGen),
    .reqTlb    (reqTlb),
    .reqTrap   (reqTrap),
    .reqIrq    (reqIrq),
    .delaySlot (delaySlot),
    .stb       (stb)
  );

  excEntryDatapath #(
    .XLEN   (XLEN),
    .CODE_W (CODE_W),
    .IMM_W  (IMM_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .resetCode   (resetCode),
    .genCode     (genCode),
    .genSlotCode (genSlotCode),
    .tlbCode     (tlbCode),
    .trapImm     (trapImm),
    .irqCode     (irqCode),
    .slotIn      (slotIn),
    .pcLoad      (pcLoad),
    .pcLoadVal   (pcLoadVal),
    .srWrEn      (srWrEn),
    .srWrData    (srWrData),
    .vbrWrEn     (vbrWrEn),
    .vbrWrData   (vbrWrData),
    .fpscrWrEn   (fpscrWrEn),
    .fpscrWrData (fpscrWrData),
    .r15In       (r15In),
    .pc          (pc),
    .nextPc      (nextPc),
    .sr          (sr),
    .ssr         (ssr),
    .spc         (spc),
    .sgr         (sgr),
    .vbr         (vbr),
    .fpscr       (fpscr),
    .expevt      (expevt),
    .intevt      (intevt),
    .tra         (tra),
    .delaySlot   (delaySlot)
  );

  excBankFile #(
    .XLEN (XLEN),
    .NREG (NREG)
  ) bank_i (
    .clk     (clk),
    .rstN    (rstN),
    .bankSel (bankSel),
    .wrEn    (gprWrEn),
    .wrIdx   (gprWrIdx),
    .wrData  (gprWrData),
    .rdIdx   (gprRdIdx),
    .rdVis   (gprRdData),
    .rdShd   (shadowRdData)
  );

endmodule

// File: tb/excEntryCtl_tb.sv
module excEntryCtl_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqReset, reqGen, reqTlb, reqTrap, reqIrq;
  logic [11:0] resetCode, genCode, genSlotCode, tlbCode, irqCode;
  logic [7:0]  trapImm;
  logic        slotIn, pcLoad, srWrEn, vbrWrEn, fpscrWrEn, gprWrEn;
  logic [31:0] pcLoadVal, srWrData, vbrWrData, fpscrWrData, gprWrData, r15In;
  logic [2:0]  gprWrIdx, gprRdIdx;
  logic [31:0] pc, nextPc, sr, ssr, spc, sgr, vbr, fpscr, tra, gprRdData, shadowRdData;
  logic [11:0] expevt, intevt;
  logic        delaySlot;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  excEntryCtl dut_i (
    .clk(clk), .rstN(rstN),
    .reqReset(reqReset), .resetCode(resetCode),
    .reqGen(reqGen), .genCode(genCode), .genSlotCode(genSlotCode),
    .reqTlb(reqTlb), .tlbCode(tlbCode),
    .reqTrap(reqTrap), .trapImm(trapImm),
    .reqIrq(reqIrq), .irqCode(irqCode),
    .slotIn(slotIn), .pcLoad(pcLoad), .pcLoadVal(pcLoadVal),
    .srWrEn(srWrEn), .srWrData(srWrData),
    .vbrWrEn(vbrWrEn), .vbrWrData(vbrWrData),
    .fpscrWrEn(fpscrWrEn), .fpscrWrData(fpscrWrData),
    .gprWrEn(gprWrEn), .gprWrIdx(gprWrIdx), .gprWrData(gprWrData),
    .gprRdIdx(gprRdIdx), .r15In(r15In),
    .pc(pc), .nextPc(nextPc), .sr(sr), .ssr(ssr), .spc(spc), .sgr(sgr),
    .vbr(vbr), .fpscr(fpscr), .expevt(expevt), .intevt(intevt), .tra(tra),
    .delaySlot(delaySlot), .gprRdData(gprRdData), .shadowRdData(shadowRdData)
  );

  localparam logic [31:0] VBASE = 32'h8C00_0000;
  localparam logic [31:0] PC0   = 32'h0C00_1000;
  localparam logic [31:0] SR0   = 32'h0000_0003;
  localparam logic [11:0] SLOTC = 12'h1A0;

  // kind: 1 general, 2 TLB miss, 3 trap (code = immediate), 4 interrupt
  // fields: {kind[2:0], slot, code[11:0], expPc[31:0], expCause[11:0]}
  localparam int NVEC = 7;
  localparam logic [59:0] VECS [NVEC] = '{
    {3'd1, 1'b0, 12'h180, 32'h8C00_0100, 12'h180},
    {3'd1, 1'b1, 12'h180, 32'h8C00_0100, 12'h1A0},
    {3'd2, 1'b0, 12'h040, 32'h8C00_0400, 12'h040},
    {3'd2, 1'b1, 12'h060, 32'h8C00_0400, 12'h060},
    {3'd3, 1'b0, 12'h021, 32'h8C00_0100, 12'h160},
    {3'd4, 1'b0, 12'h320, 32'h8C00_0600, 12'h320},
    {3'd3, 1'b1, 12'h0FF, 32'h8C00_0100, 12'h160}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearIn();
    reqReset = 0; reqGen = 0; reqTlb = 0; reqTrap = 0; reqIrq = 0;
    slotIn = 0; pcLoad = 0; srWrEn = 0; vbrWrEn = 0; fpscrWrEn = 0; gprWrEn = 0;
  endtask

  task automatic prep(input logic [31:0] srv, input logic [31:0] pcv, input logic slot);
    clearIn();
    srWrEn = 1; srWrData = srv;
    pcLoad = 1; pcLoadVal = pcv;
    vbrWrEn = 1; vbrWrData = VBASE;
    slotIn = slot;
    step();
    clearIn();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    clearIn();
    rstN = 0;
    resetCode = 0; genCode = 0; genSlotCode = SLOTC; tlbCode = 0; irqCode = 0;
    trapImm = 0; pcLoadVal = 0; srWrData = 0; vbrWrData = 0; fpscrWrData = 0;
    gprWrData = 0; gprWrIdx = 0; gprRdIdx = 3; r15In = 32'h7E00_0000;
    repeat (3) step();
    rstN = 1;
    step();

    // R1 power-on state
    chk("R1 pc", pc, 32'hA000_0000);
    chk("R1 nextPc", nextPc, 32'hA000_0002);
    chk("R1 sr", sr, 32'h7000_00F0);
    chk("R1 fpscr", fpscr, 32'h0004_0001);
    chk("R1 vbr", vbr, 32'h0);
    chk("R1 expevt", 32'(expevt), 32'h0);
    chk("R1 intevt", 32'(intevt), 32'h0);
    chk("R1 tra", tra, 32'h0);
    chk("R1 delaySlot", 32'(delaySlot), 32'h0);
    chk("R1 gpr", gprRdData, 32'h0);

    // R10 bank exchange through software status writes
    gprWrEn = 1; gprWrIdx = 3; gprWrData = 32'h11; step(); clearIn();
    chk("R10 write visible", gprRdData, 32'h11);
    chk("R10 shadow untouched", shadowRdData, 32'h0);
    srWrEn = 1; srWrData = 32'h0; step(); clearIn();
    chk("R10 swap to other bank", gprRdData, 32'h0);
    chk("R10 old bank now shadow", shadowRdData, 32'h11);
    gprWrEn = 1; gprWrIdx = 3; gprWrData = 32'h22; step(); clearIn();
    srWrEn = 1; srWrData = 32'h2000_0000; step(); clearIn();
    chk("R10 bank bit alone no swap", gprRdData, 32'h22);
    srWrEn = 1; srWrData = 32'h6000_0000; step(); clearIn();
    chk("R10 both bits swap", gprRdData, 32'h11);
    chk("R10 both bits shadow", shadowRdData, 32'h22);
    srWrEn = 1; srWrData = 32'h4000_0000; step(); clearIn();
    chk("R10 mode bit alone swaps back", gprRdData, 32'h22);
    reqGen = 1; genCode = 12'h180; step(); clearIn();
    chk("R10 entry swaps bank", gprRdData, 32'h11);

    // R11 normal pc load
    pcLoad = 1; pcLoadVal = 32'h0C00_0800; step(); clearIn();
    chk("R11 pc load", pc, 32'h0C00_0800);
    chk("R11 nextPc load", nextPc, 32'h0C00_0802);

    // table of single-request entries (R3..R8)
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0]  kind;
      logic        slot;
      logic [11:0] code, ecause;
      logic [31:0] epc;
      {kind, slot, code, epc, ecause} = VECS[i];
      prep(SR0, PC0, slot);
      chk("R8 slot loaded", 32'(delaySlot), 32'(slot));
      r15In = 32'h7E00_0000 + 32'(i);
      case (kind)
        3'd1: begin reqGen = 1; genCode = code; end
        3'd2: begin reqTlb = 1; tlbCode = code; end
        3'd3: begin reqTrap = 1; trapImm = code[7:0]; end
        default: begin reqIrq = 1; irqCode = code; end
      endcase
      step(); clearIn();
      chk("R5 vector", pc, epc);
      chk("R5 nextPc", nextPc, epc + 32'd2);
      chk("R3 spc", spc, PC0);
      chk("R3 ssr", ssr, SR0);
      chk("R3 sgr", sgr, 32'h7E00_0000 + 32'(i));
      chk("R4 sr", sr, 32'h7000_0003);
      chk("R8 slot cleared", 32'(delaySlot), 32'h0);
      if (kind == 3'd4) chk("R6 intevt", 32'(intevt), 32'(ecause));
      else chk("R6 expevt", 32'(expevt), 32'(ecause));
      if (kind == 3'd3) chk("R7 tra", tra, {22'h0, code[7:0], 2'b00});
    end

    // R9 and R2: reset beats general and interrupt, no context save
    prep(32'h0, 32'h0C00_2000, 1'b1);
    reqReset = 1; resetCode = 12'h020; reqGen = 1; genCode = 12'h0E0;
    reqIrq = 1; irqCode = 12'h3C0;
    step(); clearIn();
    chk("R2 pc", pc, 32'hA000_0000);
    chk("R2 nextPc", nextPc, 32'hA000_0002);
    chk("R2 expevt", 32'(expevt), 32'h020);
    chk("R2 sr", sr, 32'h7000_00F0);
    chk("R2 spc kept", spc, PC0);
    chk("R8 reset clears slot", 32'(delaySlot), 32'h0);
    chk("R9 intevt kept on reset", 32'(intevt), 32'h320);

    // R9: general beats TLB, trap, interrupt
    prep(32'h0, 32'h0C00_3000, 1'b0);
    reqGen = 1; genCode = 12'h0E0; reqTlb = 1; tlbCode = 12'h0A0;
    reqTrap = 1; trapImm = 8'h05; reqIrq = 1; irqCode = 12'h3C0;
    step(); clearIn();
    chk("R9 general wins pc", pc, 32'h8C00_0100);
    chk("R9 general wins expevt", 32'(expevt), 32'h0E0);
    chk("R9 trap ignored tra", tra, 32'h3FC);
    chk("R9 irq ignored intevt", 32'(intevt), 32'h320);

    // R9: TLB beats trap and interrupt
    prep(32'h0, 32'h0C00_3000, 1'b0);
    reqTlb = 1; reqTrap = 1; reqIrq = 1;
    step(); clearIn();
    chk("R9 tlb wins pc", pc, 32'h8C00_0400);
    chk("R9 tlb wins expevt", 32'(expevt), 32'h0A0);
    chk("R9 tlb tra kept", tra, 32'h3FC);

    // R9: trap beats interrupt
    prep(32'h0, 32'h0C00_3000, 1'b0);
    reqTrap = 1; reqIrq = 1;
    step(); clearIn();
    chk("R9 trap wins tra", tra, 32'h14);
    chk("R9 trap intevt kept", 32'(intevt), 32'h320);
    chk("R9 trap spc", spc, 32'h0C00_3000);

    // R11: entry overrides a same-cycle pc load and status write
    prep(32'h0, 32'h0C00_4000, 1'b0);
    reqIrq = 1; irqCode = 12'h3C0; pcLoad = 1; pcLoadVal = 32'h1234_5678;
    srWrEn = 1; srWrData = 32'h0000_0001;
    step(); clearIn();
    chk("R11 entry beats pcLoad", pc, 32'h8C00_0600);
    chk("R11 entry beats srWr", sr, 32'h7000_0000);
    chk("R6 irq intevt", 32'(intevt), 32'h3C0);
    chk("R6 irq leaves expevt", 32'(expevt), 32'h160);

    finish();
  end

endmodule